// File: doc/BRIEF.md
# Latched-Sample SPI Register Target for a Current/Voltage Monitor

This block is an SPI target that presents a two-channel 12-bit current and voltage monitor as a map of 8-bit registers with 16-bit addresses. A host opens a transaction by lowering chip select and shifting a 16-bit command word: the top bit picks read or write, and the other 15 bits give the starting address. Data bytes follow. After each data byte the address steps down by one, so a single burst can walk a block of registers from the top down.

Samples arrive from the converter on a parallel port. The four data registers do not follow that port. They hold one pair of samples, and a new pair is copied in only after the host has read all four data bytes, from the highest address down to the lowest, inside one chip-select window. The host therefore always reads a current and a voltage that were taken together. The block also decodes which addresses can be read and written, reports readiness through a status register, and has a soft reset that leaves the two configuration registers unchanged.

The SPI pins are sampled with the system clock, so SCLK must run well below the system clock (at least eight system cycles per SCLK half period).

Top module: `pmon_spi_target`

## Requirements
- R1: After reset, MISO is low, config A (0x0000) reads 0x99, config B (0x0001) reads 0x00, and the held samples are zero.
- R2: The link is SPI mode 0 with the MSB first. Bit 15 of the command word is 1 for a read and 0 for a write, and bits 14:0 are the start address.
- R3: The address goes down by one after every data byte, in both reads and writes. A burst of reads starting at 0x0203 returns 0x0203, 0x0202, 0x0201 and 0x0200 in that order.
- R4: The data bytes are laid out as follows. 0x0203 holds the current sample bits 11:8 with the upper nibble zero. 0x0202 holds current bits 7:0. 0x0201 holds voltage bits 11:8 with the upper nibble zero. 0x0200 holds voltage bits 7:0.
- R5: The sample port is copied into the held pair only when 0x0203, 0x0202, 0x0201 and 0x0200 are read one after another in a single chip-select window. The copy happens after the byte at 0x0200. That burst returns the values held before the copy. Any other access pattern leaves the held pair unchanged.
- R6: Raising chip select ends the transfer, drives MISO low and clears the progress of the descending read.
- R7: These addresses can be read: 0x0000–0x0006, 0x000C, 0x000D, 0x000F, 0x0100, 0x0103 and 0x0200–0x0203. 0x0006 returns REV_ID. 0x000C and 0x000D return the low and high bytes of VENDOR_ID. 0x0002–0x0005 return 0x00. Any other address reads as 0x00.
- R8: Only 0x0000, 0x0001, 0x000F and 0x0100 can be written. 0x000F and 0x0100 reset to 0x00 and read back what was written. Writes to any other address are ignored.
- R9: The status register 0x0103 reads 0x00 for READY_CYCLES clock cycles after reset, then reads 0x01 from then on.
- R10: Writing config B with bit 0 set starts a soft reset. It clears 0x000F, 0x0100 and the held samples, and it restarts the R9 ready delay. Config A keeps its value. Config B stores bits 7:1 of the write, and bit 0 always reads back 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sclk_i | input | 1 | SPI serial clock, idle low |
| cs_ni | input | 1 | SPI chip select, active low |
| mosi_i | input | 1 | Serial data from the host |
| miso_o | output | 1 | Serial data to the host |
| cur_sample_i | input | SAMPLE_W | Latest current sample from the converter |
| volt_sample_i | input | SAMPLE_W | Latest voltage sample from the converter |

## Verification
The descending four-byte burst is run over a sweep of sample pairs that includes all-zeros and all-ones, plus arithmetic patterns whose high and low nibbles differ. Because each burst must return the pair committed by the burst before it, this separates a correct latch from a design that reads the sample port directly or commits at the wrong byte. Incomplete sequences are also tried and must leave the held pair unchanged: a three-byte burst cut short by chip select, four single-byte reads in descending order, and a burst that starts at 0x0202. Burst writes across the configuration registers, writes to read-only addresses, and a soft reset issued with live data separate the address stepping, the write decode and the scope of the soft reset.

// File: rtl/pmon_pkg.sv
package pmon_pkg;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 8;

  localparam logic [ADDR_W-1:0] A_CFG_A  = 16'h0000;
  localparam logic [ADDR_W-1:0] A_CFG_B  = 16'h0001;
  localparam logic [ADDR_W-1:0] A_ID_END = 16'h0006;
  localparam logic [ADDR_W-1:0] A_REV    = 16'h0006;
  localparam logic [ADDR_W-1:0] A_VID_LO = 16'h000C;
  localparam logic [ADDR_W-1:0] A_VID_HI = 16'h000D;
  localparam logic [ADDR_W-1:0] A_UPD    = 16'h000F;
  localparam logic [ADDR_W-1:0] A_CTRL   = 16'h0100;
  localparam logic [ADDR_W-1:0] A_STAT   = 16'h0103;
  localparam logic [ADDR_W-1:0] A_V_LO   = 16'h0200;
  localparam logic [ADDR_W-1:0] A_V_HI   = 16'h0201;
  localparam logic [ADDR_W-1:0] A_C_LO   = 16'h0202;
  localparam logic [ADDR_W-1:0] A_C_HI   = 16'h0203;

  localparam logic [7:0] CFG_A_RST = 8'h99;

  function automatic logic is_readable(input logic [ADDR_W-1:0] a);
    return (a <= A_ID_END) || (a == A_VID_LO) || (a == A_VID_HI) ||
           (a == A_UPD) || (a == A_CTRL) || (a == A_STAT) ||
           ((a >= A_V_LO) && (a <= A_C_HI));
  endfunction

  function automatic logic is_writable(input logic [ADDR_W-1:0] a);
    return (a == A_CFG_A) || (a == A_CFG_B) || (a == A_UPD) || (a == A_CTRL);
  endfunction
endpackage

// File: rtl/pmon_sync.sv
module pmon_sync #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q[0] <= RST_VAL;
    else         stage_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= RST_VAL;
      else         stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/pmon_txn_ctrl.sv
module pmon_txn_ctrl
  import pmon_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              cs_ni,
  input  logic              mosi_i,
  output logic              miso_o,
  output logic              cs_active_o,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              rd_done_o,
  output logic [ADDR_W-1:0] done_addr_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic [DATA_W-1:0] rd_data_i
);
  localparam int CMD_W = ADDR_W;
  localparam int CNT_W = $clog2(CMD_W);
  localparam logic [CNT_W-1:0] LAST_CMD = CNT_W'(CMD_W - 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

  logic              sclk_q, cmd_phase_q, is_read_q, miso_q;
  logic              wr_en_q, rd_done_q;
  logic [CNT_W-1:0]  bit_cnt_q;
  logic [CMD_W-2:0]  shift_q;
  logic [ADDR_W-1:0] addr_q, done_addr_q;
  logic [DATA_W-1:0] tx_q, wr_data_q;
  logic [CMD_W-1:0]  cmd_word;
  logic              rise, fall, cs_active;

  assign cs_active = !cs_ni;
  assign rise      = sclk_i && !sclk_q;
  assign fall      = !sclk_i && sclk_q;
  assign cmd_word  = {shift_q, mosi_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q      <= 1'b0;
      cmd_phase_q <= 1'b1;
      is_read_q   <= 1'b0;
      miso_q      <= 1'b0;
      wr_en_q     <= 1'b0;
      rd_done_q   <= 1'b0;
      bit_cnt_q   <= '0;
      shift_q     <= '0;
      addr_q      <= '0;
      done_addr_q <= '0;
      tx_q        <= '0;
      wr_data_q   <= '0;
    end else begin
      sclk_q    <= sclk_i;
      wr_en_q   <= 1'b0;
      rd_done_q <= 1'b0;
      if (!cs_active) begin
        cmd_phase_q <= 1'b1;
        bit_cnt_q   <= '0;
        miso_q      <= 1'b0;
      end else begin
        if (rise) begin
          shift_q <= cmd_word[CMD_W-2:0];
          if (cmd_phase_q) begin
            if (bit_cnt_q == LAST_CMD) begin
              cmd_phase_q <= 1'b0;
              bit_cnt_q   <= '0;
              is_read_q   <= cmd_word[CMD_W-1];
              addr_q      <= {1'b0, cmd_word[CMD_W-2:0]};
            end else begin
              bit_cnt_q <= bit_cnt_q + 1'b1;
            end
          end else if (bit_cnt_q == LAST_BIT) begin
            bit_cnt_q   <= '0;
            addr_q      <= addr_q - 1'b1;
            done_addr_q <= addr_q;
            if (is_read_q) begin
              rd_done_q <= 1'b1;
            end else begin
              wr_en_q   <= 1'b1;
              wr_data_q <= cmd_word[DATA_W-1:0];
            end
          end else begin
            bit_cnt_q <= bit_cnt_q + 1'b1;
          end
        end
        // mode 0: next bit presented on the falling edge, byte loaded at its boundary
        if (fall && !cmd_phase_q && is_read_q) begin
          if (bit_cnt_q == '0) begin
            miso_q <= rd_data_i[DATA_W-1];
            tx_q   <= {rd_data_i[DATA_W-2:0], 1'b0};
          end else begin
            miso_q <= tx_q[DATA_W-1];
            tx_q   <= {tx_q[DATA_W-2:0], 1'b0};
          end
        end
      end
    end
  end

  assign miso_o      = miso_q;
  assign cs_active_o = cs_active;
  assign wr_en_o     = wr_en_q;
  assign wr_addr_o   = done_addr_q;
  assign wr_data_o   = wr_data_q;
  assign rd_done_o   = rd_done_q;
  assign done_addr_o = done_addr_q;
  assign rd_addr_o   = addr_q;

  a_r6_miso_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_active |=> !miso_o);
  a_r3_addr_steps_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_done_q |-> (addr_q == done_addr_q - 1'b1));
  a_r2_single_direction: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_q && rd_done_q));
endmodule

// File: rtl/pmon_ready_timer.sv
module pmon_ready_timer #(
  parameter int CYCLES = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  output logic ready_o
);
  localparam int CW = $clog2(CYCLES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(CYCLES);

  logic [CW-1:0] cnt_q;

  assign ready_o = (cnt_q == LIMIT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (restart_i) cnt_q <= '0;
    else if (!ready_o)  cnt_q <= cnt_q + 1'b1;
  end

  a_r10_restart_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> !ready_o);
  a_r9_ready_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && !restart_i) |=> ready_o);
endmodule

// File: rtl/pmon_reg_map.sv
module pmon_reg_map
  import pmon_pkg::*;
#(
  parameter int SAMPLE_W = 12,
  parameter int READY_CYCLES = 32,
  parameter logic [7:0] REV_ID = 8'h01,
  parameter logic [15:0] VENDOR_ID = 16'h0104
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cs_active_i,
  input  logic                wr_en_i,
  input  logic [ADDR_W-1:0]   wr_addr_i,
  input  logic [DATA_W-1:0]   wr_data_i,
  input  logic                rd_done_i,
  input  logic [ADDR_W-1:0]   done_addr_i,
  input  logic [ADDR_W-1:0]   rd_addr_i,
  output logic [DATA_W-1:0]   rd_data_o,
  input  logic [SAMPLE_W-1:0] cur_i,
  input  logic [SAMPLE_W-1:0] volt_i
);
  localparam int DATA_BYTES = 4;
  localparam int SEQ_W = $clog2(DATA_BYTES);
  localparam logic [SEQ_W-1:0] SEQ_LAST = SEQ_W'(DATA_BYTES - 1);

  logic [7:0]          cfg_a_q, upd_q, ctrl_q;
  logic [7:1]          cfg_b_q;
  logic [SAMPLE_W-1:0] held_c_q, held_v_q;
  logic [SEQ_W-1:0]    seq_q;
  logic                soft_rst, ready;
  logic [ADDR_W-1:0]   exp_addr;
  logic [15:0]         cur16, volt16;

  assign soft_rst = wr_en_i && (wr_addr_i == A_CFG_B) && wr_data_i[0];
  assign exp_addr = A_C_HI - ADDR_W'(seq_q);
  assign cur16    = 16'(held_c_q);
  assign volt16   = 16'(held_v_q);

  pmon_ready_timer #(.CYCLES(READY_CYCLES)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (soft_rst),
    .ready_o   (ready)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_a_q <= CFG_A_RST;
      cfg_b_q <= '0;
      upd_q   <= '0;
      ctrl_q  <= '0;
    end else begin
      if (wr_en_i && is_writable(wr_addr_i)) begin
        unique case (wr_addr_i)
          A_CFG_A: cfg_a_q <= wr_data_i;
          A_CFG_B: cfg_b_q <= wr_data_i[7:1];
          A_UPD:   upd_q   <= wr_data_i;
          default: ctrl_q  <= wr_data_i;
        endcase
      end
      if (soft_rst) begin
        upd_q  <= '0;
        ctrl_q <= '0;
      end
    end
  end

  // descending-read tracker and sample commit
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seq_q    <= '0;
      held_c_q <= '0;
      held_v_q <= '0;
    end else if (!cs_active_i || wr_en_i) begin
      seq_q <= '0;
      if (soft_rst) begin
        held_c_q <= '0;
        held_v_q <= '0;
      end
    end else if (rd_done_i) begin
      if (done_addr_i == exp_addr) begin
        if (seq_q == SEQ_LAST) begin
          seq_q    <= '0;
          held_c_q <= cur_i;
          held_v_q <= volt_i;
        end else begin
          seq_q <= seq_q + 1'b1;
        end
      end else if (done_addr_i == A_C_HI) begin
        seq_q <= SEQ_W'(1);
      end else begin
        seq_q <= '0;
      end
    end
  end

  always_comb begin
    rd_data_o = '0;
    if (is_readable(rd_addr_i)) begin
      unique case (rd_addr_i)
        A_CFG_A:  rd_data_o = cfg_a_q;
        A_CFG_B:  rd_data_o = {cfg_b_q, 1'b0};
        A_REV:    rd_data_o = REV_ID;
        A_VID_LO: rd_data_o = VENDOR_ID[7:0];
        A_VID_HI: rd_data_o = VENDOR_ID[15:8];
        A_UPD:    rd_data_o = upd_q;
        A_CTRL:   rd_data_o = ctrl_q;
        A_STAT:   rd_data_o = {7'b0, ready};
        A_V_LO:   rd_data_o = volt16[7:0];
        A_V_HI:   rd_data_o = volt16[15:8];
        A_C_LO:   rd_data_o = cur16[7:0];
        A_C_HI:   rd_data_o = cur16[15:8];
        default:  rd_data_o = '0;
      endcase
    end
  end

  a_r5_hold_until_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_done_i && done_addr_i != A_V_LO) |=> ($stable(held_c_q) && $stable(held_v_q)));
  a_r10_cfg_a_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst |=> $stable(cfg_a_q));
  a_r8_ignored_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !is_writable(wr_addr_i)) |=>
      ($stable(cfg_a_q) && $stable(cfg_b_q) && $stable(upd_q) && $stable(ctrl_q)));
endmodule

// File: rtl/pmon_spi_target.sv
module pmon_spi_target
  import pmon_pkg::*;
#(
  parameter int SAMPLE_W = 12,
  parameter int SYNC_STAGES = 2,
  parameter int READY_CYCLES = 32,
  parameter logic [7:0] REV_ID = 8'h01,
  parameter logic [15:0] VENDOR_ID = 16'h0104
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                sclk_i,
  input  logic                cs_ni,
  input  logic                mosi_i,
  output logic                miso_o,
  input  logic [SAMPLE_W-1:0] cur_sample_i,
  input  logic [SAMPLE_W-1:0] volt_sample_i
);
  logic [2:0]        pins_s;
  logic              cs_active, wr_en, rd_done;
  logic [ADDR_W-1:0] wr_addr, done_addr, rd_addr;
  logic [DATA_W-1:0] wr_data, rd_data;

  pmon_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({sclk_i, cs_ni, mosi_i}),
    .q_o    (pins_s)
  );

  pmon_txn_ctrl u_txn (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sclk_i      (pins_s[2]),
    .cs_ni       (pins_s[1]),
    .mosi_i      (pins_s[0]),
    .miso_o      (miso_o),
    .cs_active_o (cs_active),
    .wr_en_o     (wr_en),
    .wr_addr_o   (wr_addr),
    .wr_data_o   (wr_data),
    .rd_done_o   (rd_done),
    .done_addr_o (done_addr),
    .rd_addr_o   (rd_addr),
    .rd_data_i   (rd_data)
  );

  pmon_reg_map #(
    .SAMPLE_W     (SAMPLE_W),
    .READY_CYCLES (READY_CYCLES),
    .REV_ID       (REV_ID),
    .VENDOR_ID    (VENDOR_ID)
  ) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cs_active_i (cs_active),
    .wr_en_i     (wr_en),
    .wr_addr_i   (wr_addr),
    .wr_data_i   (wr_data),
    .rd_done_i   (rd_done),
    .done_addr_i (done_addr),
    .rd_addr_i   (rd_addr),
    .rd_data_o   (rd_data),
    .cur_i       (cur_sample_i),
    .volt_i      (volt_sample_i)
  );
endmodule

// File: tb/pmon_spi_target_test.sv
module pmon_spi_target_test;
  localparam int HALF = 8;
  localparam int READY = 2000;
  localparam logic [7:0] REV = 8'h2C;
  localparam logic [15:0] VID = 16'h51A7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic miso;
  logic [11:0] cur_in = '0, volt_in = '0;
  logic [7:0] tx [4];
  logic [7:0] rx [4];
  int n_chk = 0, n_bad = 0;
  logic [11:0] exp_c = '0, exp_v = '0;

  always #5 clk = ~clk;

  pmon_spi_target #(.READY_CYCLES(READY), .REV_ID(REV), .VENDOR_ID(VID)) uut (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .cs_ni(cs_n), .mosi_i(mosi),
    .miso_o(miso), .cur_sample_i(cur_in), .volt_sample_i(volt_in)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic bit_xfer(input logic b, output logic s);
    mosi = b;
    repeat (HALF) @(negedge clk);
    sclk = 1'b1;
    s = miso;
    repeat (HALF) @(negedge clk);
    sclk = 1'b0;
  endtask

  // R2: command {rd, addr[14:0]}, MSB first
  task automatic xfer(input logic rd, input logic [14:0] a, input int n);
    logic [15:0] cmd;
    logic s;
    cmd = {rd, a};
    @(negedge clk);
    cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int i = 15; i >= 0; i--) bit_xfer(cmd[i], s);
    for (int k = 0; k < n; k++) begin
      for (int i = 7; i >= 0; i--) begin
        bit_xfer(tx[k][i], s);
        rx[k][i] = s;
      end
    end
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    repeat (2 * HALF) @(negedge clk);
  endtask

  task automatic rd1(input logic [14:0] a, output logic [7:0] d);
    xfer(1'b1, a, 1);
    d = rx[0];
  endtask

  task automatic wr1(input logic [14:0] a, input logic [7:0] d);
    tx[0] = d;
    xfer(1'b0, a, 1);
  endtask

  task automatic burst_check(input string req);
    xfer(1'b1, 15'h0203, 4);
    check(req, rx[0], {4'h0, exp_c[11:8]});
    check(req, rx[1], exp_c[7:0]);
    check(req, rx[2], {4'h0, exp_v[11:8]});
    check(req, rx[3], exp_v[7:0]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] d;
    for (int k = 0; k < 4; k++) tx[k] = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 miso idle", {7'b0, miso}, 8'h00);

    rd1(15'h0103, d); check("R9 status before ready", d, 8'h00);
    rd1(15'h0000, d); check("R1 config A reset", d, 8'h99);
    rd1(15'h0001, d); check("R1 config B reset", d, 8'h00);

    rd1(15'h0007, d); check("R7 unreadable 0x0007", d, 8'h00);
    rd1(15'h0300, d); check("R7 unreadable 0x0300", d, 8'h00);
    rd1(15'h0004, d); check("R7 id gap 0x0004", d, 8'h00);
    rd1(15'h0006, d); check("R7 revision", d, REV);
    rd1(15'h000C, d); check("R7 vendor low", d, VID[7:0]);
    rd1(15'h000D, d); check("R7 vendor high", d, VID[15:8]);

    wr1(15'h000F, 8'h5A); rd1(15'h000F, d); check("R8 update reg", d, 8'h5A);
    wr1(15'h0100, 8'hA5); rd1(15'h0100, d); check("R8 control reg", d, 8'hA5);
    wr1(15'h0006, 8'h77); rd1(15'h0006, d); check("R8 read-only revision", d, REV);
    wr1(15'h000C, 8'h33); rd1(15'h000C, d); check("R8 read-only vendor", d, VID[7:0]);

    // R3 burst write 0x0001 then 0x0000
    tx[0] = 8'h42; tx[1] = 8'h3C;
    xfer(1'b0, 15'h0001, 2);
    xfer(1'b1, 15'h0001, 2);
    check("R3 burst write cfg B", rx[0], 8'h42);
    check("R3 burst write cfg A", rx[1], 8'h3C);

    // R4/R5 sweep: each burst returns the pair committed by the previous one
    for (int i = 0; i < 18; i++) begin
      logic [11:0] c, v;
      c = 12'((i * 1237 + 3) % 4096);
      v = 12'((i * 2741 + 1000) % 4096);
      if (i == 16) begin c = 12'hFFF; v = 12'hFFF; end
      if (i == 17) begin c = 12'h000; v = 12'hF0F; end
      cur_in = c; volt_in = v;
      burst_check(i == 0 ? "R1 held zero" : "R4 R5 sweep");
      exp_c = c; exp_v = v;
    end

    // R6 partial bursts and other patterns do not commit
    cur_in = 12'hABC; volt_in = 12'h123;
    xfer(1'b1, 15'h0203, 3);
    rd1(15'h0203, d); rd1(15'h0202, d); rd1(15'h0201, d); rd1(15'h0200, d);
    check("R6 single reads keep held", d, exp_v[7:0]);
    xfer(1'b1, 15'h0202, 3);
    check("R5 burst from 0x0202", rx[0], exp_c[7:0]);
    burst_check("R6 after aborted burst");
    exp_c = 12'hABC; exp_v = 12'h123;
    burst_check("R5 commit after full burst");

    rd1(15'h0103, d); check("R9 status ready", d, 8'h01);

    // R10 soft reset
    wr1(15'h0001, 8'h43);
    rd1(15'h0103, d); check("R10 status restarted", d, 8'h00);
    rd1(15'h0001, d); check("R10 cfg B bit0 clear", d, 8'h42);
    rd1(15'h0000, d); check("R10 cfg A kept", d, 8'h3C);
    rd1(15'h000F, d); check("R10 update cleared", d, 8'h00);
    rd1(15'h0100, d); check("R10 control cleared", d, 8'h00);
    exp_c = '0; exp_v = '0;
    burst_check("R10 held cleared");
    repeat (READY + 100) @(negedge clk);
    rd1(15'h0103, d); check("R10 R9 ready again", d, 8'h01);
    check("R6 miso idle at end", {7'b0, miso}, 8'h00);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule